// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block moves single command or status words between two ports that run on unrelated clocks. It holds two 36-bit registers, one for each direction. Port A loads the forward register, and port B unloads it. Port B loads the return register, and port A unloads it. Each port presents a chip select, a direction bit, an enable and a mailbox-select input. An access with mailbox-select low belongs to a neighbouring queue and leaves the mailboxes untouched.

Each register has an active-low full flag in its writer's clock domain. A write drops the flag and locks the word in place. The flag rises again only after the far side has read the word and that read has crossed back through a synchronizer. A writer therefore polls its flag and never overruns a word that has not been consumed. The flag is built from a pair of toggles. The write toggle is synchronized into the reader domain, where it marks the word as present. The read toggle is synchronized back, where it releases the flag.

Top module: `mbx_pair`

## Requirements
- R1: After reset both full flags are high, and a mailbox read on either port returns all zeros.
- R2: A port-A access with chip select, enable, write direction (wr=1) and mailbox-select all high stores its data in the forward register, and a later port-B mailbox read returns that word. A port-B write stores into the return register in the same way, and a port-A mailbox read returns it.
- R3: A write access with mailbox-select low changes neither the register nor its flag.
- R4: An accepted write drives the writer's full flag low, as seen right after the clock edge that stores the word.
- R5: While a full flag is low, further writes to that register are ignored and the stored word is kept.
- R6: A mailbox read (wr=0, chip select, enable and mailbox-select high) by the far side, made at least two reader-clock edges after the write, releases the flag. The flag is still low at the first writer-clock falling edge after the read edge, and it is high within four writer-clock cycles.
- R7: A port's read-data output shows the register it unloads while a mailbox read is selected on that port, and shows zero otherwise.
- R8: A read with mailbox-select, chip select or enable low does not release the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_cs_i | input | 1 | Port A chip select |
| a_wr_i | input | 1 | Port A direction, 1 = write |
| a_en_i | input | 1 | Port A enable |
| a_mbx_i | input | 1 | Port A mailbox select |
| a_data_i | input | 36 | Port A write data |
| a_data_o | output | 36 | Port A read data (return register) |
| mbf1_n_o | output | 1 | Forward register full, active low, clk_a domain |
| b_cs_i | input | 1 | Port B chip select |
| b_wr_i | input | 1 | Port B direction, 1 = write |
| b_en_i | input | 1 | Port B enable |
| b_mbx_i | input | 1 | Port B mailbox select |
| b_data_i | input | 36 | Port B write data |
| b_data_o | output | 36 | Port B read data (forward register) |
| mbf2_n_o | output | 1 | Return register full, active low, clk_b domain |

## Verification
The hardest case is the release of a flag across the clock boundary. The flag must stay low right after the far-side read, and it must come back within a bounded number of writer cycles, with the two clocks at unrelated periods of 5 ns and 7 ns. The read task forks a watcher on the writer's first falling edge after the read edge, while the reader deasserts its strobe on its own clock. This catches a flag that releases early, never releases, or releases on a read that should be ignored. A second write issued while the flag is low, followed by a read, shows whether the first word survived.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  parameter int unsigned MBX_W       = 36;
  parameter int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int unsigned W      = 36,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_w_i,
  input  logic         clk_r_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_i,
  output logic [W-1:0] rd_data_o,
  output logic         full_n_o
);
  logic [W-1:0] mail_q;
  logic         wr_tgl_q, ack_sync;
  logic         rd_tgl_q, wr_sync;
  logic         avail;

  // writer domain
  assign full_n_o = (wr_tgl_q == ack_sync);

  always_ff @(posedge clk_w_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mail_q   <= '0;
      wr_tgl_q <= 1'b0;
    end else if (wr_i && full_n_o) begin
      mail_q   <= wr_data_i;
      wr_tgl_q <= ~wr_tgl_q;
    end
  end

  mbx_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk_i(clk_w_i), .rst_ni(rst_ni), .d_i(rd_tgl_q), .q_o(ack_sync)
  );

  // reader domain; word is stable while flag low
  mbx_sync #(.STAGES(STAGES)) u_wr_sync (
    .clk_i(clk_r_i), .rst_ni(rst_ni), .d_i(wr_tgl_q), .q_o(wr_sync)
  );

  assign avail = (wr_sync != rd_tgl_q);

  always_ff @(posedge clk_r_i or negedge rst_ni) begin
    if (!rst_ni)            rd_tgl_q <= 1'b0;
    else if (rd_i && avail) rd_tgl_q <= wr_sync;
  end

  assign rd_data_o = rd_i ? mail_q : '0;

  p_flag_low_on_write_r4: assert property (@(posedge clk_w_i) disable iff (!rst_ni)
    (wr_i && full_n_o) |=> !full_n_o);

  p_hold_when_full_r5: assert property (@(posedge clk_w_i) disable iff (!rst_ni)
    !full_n_o |=> $stable(mail_q));

  p_no_ack_unless_avail_r6: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    !avail |=> $stable(rd_tgl_q));

  p_ack_consumes_r6: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    (rd_i && avail) |=> !avail);
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
  import mbx_pkg::*;
#(
  parameter int unsigned W      = MBX_W,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic         clk_a_i,
  input  logic         clk_b_i,
  input  logic         rst_ni,
  input  logic         a_cs_i,
  input  logic         a_wr_i,
  input  logic         a_en_i,
  input  logic         a_mbx_i,
  input  logic [W-1:0] a_data_i,
  output logic [W-1:0] a_data_o,
  output logic         mbf1_n_o,
  input  logic         b_cs_i,
  input  logic         b_wr_i,
  input  logic         b_en_i,
  input  logic         b_mbx_i,
  input  logic [W-1:0] b_data_i,
  output logic [W-1:0] b_data_o,
  output logic         mbf2_n_o
);
  logic a_sel, b_sel;
  logic a_wr_stb, a_rd_stb, b_wr_stb, b_rd_stb;

  assign a_sel    = a_cs_i & a_en_i & a_mbx_i;
  assign b_sel    = b_cs_i & b_en_i & b_mbx_i;
  assign a_wr_stb = a_sel &  a_wr_i;
  assign a_rd_stb = a_sel & ~a_wr_i;
  assign b_wr_stb = b_sel &  b_wr_i;
  assign b_rd_stb = b_sel & ~b_wr_i;

  // forward: A -> B
  mbx_channel #(.W(W), .STAGES(STAGES)) u_fwd (
    .clk_w_i(clk_a_i), .clk_r_i(clk_b_i), .rst_ni(rst_ni),
    .wr_i(a_wr_stb), .wr_data_i(a_data_i),
    .rd_i(b_rd_stb), .rd_data_o(b_data_o), .full_n_o(mbf1_n_o)
  );

  // return: B -> A
  mbx_channel #(.W(W), .STAGES(STAGES)) u_ret (
    .clk_w_i(clk_b_i), .clk_r_i(clk_a_i), .rst_ni(rst_ni),
    .wr_i(b_wr_stb), .wr_data_i(b_data_i),
    .rd_i(a_rd_stb), .rd_data_o(a_data_o), .full_n_o(mbf2_n_o)
  );

  p_no_write_without_mbx_a_r3: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (a_cs_i && a_en_i && a_wr_i && !a_mbx_i && mbf1_n_o) |=> mbf1_n_o);

  p_no_write_without_mbx_b_r3: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (b_cs_i && b_en_i && b_wr_i && !b_mbx_i && mbf2_n_o) |=> mbf2_n_o);
endmodule

// File: tb/tb_mbx_pair.sv
`timescale 1ns/1ps
module tb_mbx_pair;
  localparam int W = 36;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic a_cs = 0, a_wr = 0, a_en = 0, a_mbx = 0;
  logic b_cs = 0, b_wr = 0, b_en = 0, b_mbx = 0;
  logic [W-1:0] a_d = '0, b_d = '0, a_q, b_q;
  logic mbf1_n, mbf2_n;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;

  mbx_pair dut (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .a_cs_i(a_cs), .a_wr_i(a_wr), .a_en_i(a_en), .a_mbx_i(a_mbx),
    .a_data_i(a_d), .a_data_o(a_q), .mbf1_n_o(mbf1_n),
    .b_cs_i(b_cs), .b_wr_i(b_wr), .b_en_i(b_en), .b_mbx_i(b_mbx),
    .b_data_i(b_d), .b_data_o(b_q), .mbf2_n_o(mbf2_n)
  );

  // {writer side (0=A,1=B), mbx, data}
  localparam logic [37:0] VEC [8] = '{
    {1'b0, 1'b1, 36'h1_2345_6789},
    {1'b1, 1'b1, 36'hA_BCDE_F012},
    {1'b0, 1'b0, 36'hF_FFFF_FFFF},
    {1'b0, 1'b1, 36'h8_0000_0001},
    {1'b1, 1'b0, 36'h5_5555_5555},
    {1'b1, 1'b1, 36'h0_0000_0000},
    {1'b0, 1'b1, 36'hF_FFFF_FFFF},
    {1'b1, 1'b1, 36'h7_0F0F_0F0E}
  };

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_side(input bit side, input logic mbx, input logic [W-1:0] d);
    if (!side) begin
      @(negedge clk_a); a_cs = 1; a_wr = 1; a_en = 1; a_mbx = mbx; a_d = d;
      @(negedge clk_a); a_cs = 0; a_wr = 0; a_en = 0; a_mbx = 0;
    end else begin
      @(negedge clk_b); b_cs = 1; b_wr = 1; b_en = 1; b_mbx = mbx; b_d = d;
      @(negedge clk_b); b_cs = 0; b_wr = 0; b_en = 0; b_mbx = 0;
    end
  endtask

  // side = reader side; early = writer flag at first writer negedge after read edge
  task automatic rd_side(input bit side, input logic cs, input logic en, input logic mbx,
                         output logic [W-1:0] q, output logic early);
    if (side) begin
      @(negedge clk_b); b_cs = cs; b_wr = 0; b_en = en; b_mbx = mbx;
      #1 q = b_q;
      @(posedge clk_b);
      fork
        begin @(negedge clk_a); early = mbf1_n; end
        begin @(negedge clk_b); b_cs = 0; b_en = 0; b_mbx = 0; end
      join
    end else begin
      @(negedge clk_a); a_cs = cs; a_wr = 0; a_en = en; a_mbx = mbx;
      #1 q = a_q;
      @(posedge clk_a);
      fork
        begin @(negedge clk_b); early = mbf2_n; end
        begin @(negedge clk_a); a_cs = 0; a_en = 0; a_mbx = 0; end
      join
    end
  endtask

  task automatic wait_side(input bit side, input int n);
    repeat (n) if (side) @(negedge clk_b); else @(negedge clk_a);
  endtask

  function automatic logic flag_of(input bit side);
    return side ? mbf2_n : mbf1_n;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%h expected=%h", 36'h0, 36'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] last [2];
    logic [W-1:0] q;
    logic early;
    last[0] = '0; last[1] = '0;
    repeat (3) @(negedge clk_a);
    rst_n = 1;
    repeat (2) @(negedge clk_b);

    // R1 reset state
    chk(mbf1_n === 1'b1, "R1 mbf1", W'(mbf1_n), W'(1));
    chk(mbf2_n === 1'b1, "R1 mbf2", W'(mbf2_n), W'(1));
    rd_side(1, 1, 1, 1, q, early);
    chk(q === '0, "R1 fwd zero", q, '0);
    rd_side(0, 1, 1, 1, q, early);
    chk(q === '0, "R1 ret zero", q, '0);

    // vector walk: R2 R3 R4 R6 R7
    foreach (VEC[i]) begin
      bit ws;
      logic mb;
      logic [W-1:0] d;
      ws = VEC[i][37]; mb = VEC[i][36]; d = VEC[i][35:0];
      wr_side(ws, mb, d);
      if (mb) begin
        last[ws] = d;
        chk(flag_of(ws) === 1'b0, "R4 flag low after write", W'(flag_of(ws)), '0);
      end else begin
        chk(flag_of(ws) === 1'b1, "R3 no mbx write", W'(flag_of(ws)), W'(1));
      end
      wait_side(!ws, 4);
      rd_side(!ws, 1, 1, 1, q, early);
      chk(q === last[ws], "R2 R7 read data", q, last[ws]);
      if (mb) chk(early === 1'b0, "R6 flag held after read", W'(early), '0);
      wait_side(ws, 5);
      chk(flag_of(ws) === 1'b1, "R6 flag released", W'(flag_of(ws)), W'(1));
    end

    // R5 second write while full ignored
    wr_side(0, 1, 36'h3_3333_3333);
    wr_side(0, 1, 36'hC_CCCC_CCCC);
    chk(mbf1_n === 1'b0, "R5 still full", W'(mbf1_n), '0);
    wait_side(1, 4);
    rd_side(1, 1, 1, 1, q, early);
    chk(q === 36'h3_3333_3333, "R5 word kept", q, 36'h3_3333_3333);
    wait_side(0, 5);
    chk(mbf1_n === 1'b1, "R6 release after R5", W'(mbf1_n), W'(1));

    // R8 non-qualifying reads do not release; R7 output zero
    wr_side(1, 1, 36'h9_8765_4321);
    wait_side(0, 4);
    rd_side(0, 1, 1, 0, q, early);
    chk(q === '0, "R7 zero without mbx", q, '0);
    rd_side(0, 0, 1, 1, q, early);
    chk(q === '0, "R7 zero without cs", q, '0);
    rd_side(0, 1, 0, 1, q, early);
    wait_side(1, 6);
    chk(mbf2_n === 1'b0, "R8 not released", W'(mbf2_n), '0);
    rd_side(0, 1, 1, 1, q, early);
    chk(q === 36'h9_8765_4321, "R2 return word", q, 36'h9_8765_4321);
    chk(early === 1'b0, "R6 held return", W'(early), '0);
    wait_side(1, 5);
    chk(mbf2_n === 1'b1, "R6 return released", W'(mbf2_n), W'(1));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule